// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a record of loads that a pipeline has hoisted above older stores that might write the same memory. Each hoisted load writes an entry holding its destination register number and the bytes it read. A later store removes every entry whose bytes it touches. When the pipeline reaches the point where the loaded value is first needed, it presents the register number on the check port. A hit means no conflicting store came between, so the value can be used as it is. A miss tells the pipeline to re-execute the load or to branch to recovery code.

The table is fully associative. It is keyed by register number, and a register has at most one entry. When no entry is free, a round-robin pointer chooses the victim, and the load it held will then miss at its check. A check can ask for its entry to be removed once it has been looked up. A speculative load that deferred a fault leaves no valid entry behind, so its check is sure to fail.

Top module: `spec_ld_table`

## Requirements
- R1: After reset the table holds no entries, and every check reports a miss.
- R2: An insert with `ins_valid`=1 and `ins_defer`=0 writes an entry for `ins_reg`. A check of that register in any later cycle reports a hit until something removes the entry.
- R3: `chk_hit` is combinational. It reflects the table as it stood at the start of the cycle, so an insert, store or clear in the same cycle is not yet seen. `chk_hit` is 0 whenever `chk_valid` is 0.
- R4: A store removes, at the next clock edge, every valid entry that shares at least one byte with it.
- R5: Overlap is decided at byte level inside 8-byte aligned words. Bits [2:0] of the address give the starting byte, and the size code 0/1/2/3 means 1/2/4/8 bytes. Bytes that would fall past the end of the word are dropped. A store to another word, or to bytes of the same word that do not overlap, leaves the entry valid.
- R6: A check with `chk_clear`=1 reports hit or miss as usual and then removes the matching entry.
- R7: An insert with `ins_defer`=1 allocates nothing and removes any existing entry for `ins_reg`.
- R8: An insert to a register that already has an entry overwrites that entry in place. Only the newest address counts for later stores.
- R9: When an insert and a store occur in the same cycle, the store is compared only against the new address of the written entry. The entry ends valid exactly when those two do not overlap.
- R10: If an insert needs a new entry and every entry is valid, the entry under the round-robin pointer is replaced. The pointer starts at entry 0 after reset and advances by one, wrapping, only when such a replacement occurs.
- R11: If one or more entries are free, a new register takes the lowest-numbered free entry, and the pointer does not move.
- R12: When an insert and a clearing check of the same register occur in the same cycle, the insert wins and the entry ends valid with the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Speculative load insert request |
| ins_defer | input | 1 | The load deferred a fault: allocate nothing and drop the register's entry |
| ins_reg | input | REG_W | Destination register number of the load |
| ins_addr | input | ADDR_W | Byte address of the load |
| ins_size | input | 2 | Load size code (0:1, 1:2, 2:4, 3:8 bytes) |
| st_valid | input | 1 | Store probe request |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Store size code (0:1, 1:2, 2:4, 3:8 bytes) |
| chk_valid | input | 1 | Check request |
| chk_clear | input | 1 | Remove the matching entry after the check |
| chk_reg | input | REG_W | Register number to check |
| chk_hit | output | 1 | Combinational check result: 1 when a valid entry exists for the register |

## Verification
The bench builds the table with 4 entries, 6-bit register numbers and 16-bit addresses. With only 4 entries, the table fills after a handful of inserts. That brings into reach the round-robin eviction, the wrap of the pointer, the fact that the pointer holds still while a free entry is taken, and the lowest-free-first choice, all within a few dozen cycles. The 16-bit address still leaves room for many distinct 8-byte words, so the bench can probe byte-lane overlap, stores to neighbouring words and sizes that run past the end of a word.

// File: rtl/sltab_pkg.sv
package sltab_pkg;
    localparam int unsigned WORD_BYTES = 8;
    localparam int unsigned OFF_W      = $clog2(WORD_BYTES);

    // Byte lanes touched inside one aligned word; lanes past the word end are dropped.
    function automatic logic [WORD_BYTES-1:0] lane_mask(
        input logic [OFF_W-1:0] off,
        input logic [1:0]       size
    );
        logic [WORD_BYTES-1:0]   fill;
        logic [2*WORD_BYTES-1:0] span;
        case (size)
            2'd0:    fill = WORD_BYTES'(8'h01);
            2'd1:    fill = WORD_BYTES'(8'h03);
            2'd2:    fill = WORD_BYTES'(8'h0F);
            default: fill = WORD_BYTES'(8'hFF);
        endcase
        span = {{WORD_BYTES{1'b0}}, fill} << off;
        return span[WORD_BYTES-1:0];
    endfunction
endpackage

// File: rtl/sltab_entry.sv
module sltab_entry #(
    parameter int unsigned REG_W  = 7,
    parameter int unsigned LINE_W = 29
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [REG_W-1:0]                 wr_tag,
    input  logic [LINE_W-1:0]                wr_line,
    input  logic [sltab_pkg::WORD_BYTES-1:0] wr_mask,
    input  logic                             kill,
    input  logic                             st_valid,
    input  logic [LINE_W-1:0]                st_line,
    input  logic [sltab_pkg::WORD_BYTES-1:0] st_mask,
    output logic                             valid_o,
    output logic [REG_W-1:0]                 tag_o,
    output logic                             st_conflict_o
);
    typedef struct packed {
        logic                             valid;
        logic [REG_W-1:0]                 tag;
        logic [LINE_W-1:0]                line;
        logic [sltab_pkg::WORD_BYTES-1:0] mask;
    } ent_t;

    ent_t ent_d, ent_q;
    logic new_conflict;

    always_comb begin
        st_conflict_o = ent_q.valid && st_valid && (ent_q.line == st_line)
                        && (|(ent_q.mask & st_mask));
        new_conflict  = st_valid && (wr_line == st_line) && (|(wr_mask & st_mask));
        ent_d = ent_q;
        if (wr_en) begin
            ent_d.valid = !new_conflict;
            ent_d.tag   = wr_tag;
            ent_d.line  = wr_line;
            ent_d.mask  = wr_mask;
        end else if (kill || st_conflict_o) begin
            ent_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign valid_o = ent_q.valid;
    assign tag_o   = ent_q.tag;

    // R4: an overlapping store with no write in the same cycle leaves the entry empty
    a_r4_store_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (st_conflict_o && !wr_en) |=> !valid_o);

    // R9: a write paired with a store to another word always survives
    a_r9_write_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_valid && (st_line != wr_line)) |=> valid_o);

    // R1: the slot comes out of reset empty
    a_r1_reset_empty: assert property (@(posedge clk)
        $rose(rst_n) |-> !valid_o);
endmodule

// File: rtl/sltab_victim.sv
module sltab_victim #(
    parameter int unsigned ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] same_reg_i,
    output logic [ENTRIES-1:0] sel_o
);
    localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } vic_t;

    vic_t vic_d, vic_q;
    logic found;
    logic evict;

    always_comb begin
        sel_o = '0;
        found = 1'b0;
        evict = 1'b0;
        vic_d = vic_q;
        if (|same_reg_i) begin
            sel_o = same_reg_i;
        end else begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                if (!valid_i[i] && !found) begin
                    sel_o[i] = 1'b1;
                    found    = 1'b1;
                end
            end
            if (!found) begin
                sel_o[vic_q.ptr] = 1'b1;
                evict            = alloc;
            end
        end
        if (evict) begin
            vic_d.ptr = (vic_q.ptr == PTR_LAST) ? '0 : vic_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vic_q <= '0;
        else        vic_q <= vic_d;
    end

    // R10: a replacement always moves the pointer on
    a_r10_ptr_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && (&valid_i) && !(|same_reg_i)) |=> (vic_q.ptr != $past(vic_q.ptr)) || (ENTRIES == 1));

    // R11: taking a free slot leaves the pointer where it was
    a_r11_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&valid_i)) |=> $stable(vic_q.ptr));

    // R8 / R11: exactly one slot is chosen for each allocation
    a_r11_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> $onehot(sel_o));
endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned REG_W   = 7,
    parameter int unsigned ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic              ins_defer,
    input  logic [REG_W-1:0]  ins_reg,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [1:0]        ins_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              chk_valid,
    input  logic              chk_clear,
    input  logic [REG_W-1:0]  chk_reg,
    output logic              chk_hit
);
    import sltab_pkg::*;

    localparam int unsigned LINE_W = ADDR_W - OFF_W;

    logic [ENTRIES-1:0]    valid_v;
    logic [ENTRIES-1:0]    st_hit_v;
    logic [ENTRIES-1:0]    chk_match;
    logic [ENTRIES-1:0]    ins_match;
    logic [ENTRIES-1:0]    kill_v;
    logic [ENTRIES-1:0]    wr_v;
    logic [ENTRIES-1:0]    sel_v;
    logic [REG_W-1:0]      tag_v [ENTRIES];
    logic [LINE_W-1:0]     ins_line;
    logic [LINE_W-1:0]     st_line;
    logic [WORD_BYTES-1:0] ins_mask;
    logic [WORD_BYTES-1:0] st_mask;
    logic                  alloc;

    always_comb begin
        ins_line = ins_addr[ADDR_W-1:OFF_W];
        st_line  = st_addr[ADDR_W-1:OFF_W];
        ins_mask = lane_mask(ins_addr[OFF_W-1:0], ins_size);
        st_mask  = lane_mask(st_addr[OFF_W-1:0], st_size);
        alloc    = ins_valid && !ins_defer;
        wr_v     = alloc ? sel_v : '0;
        kill_v   = ((chk_valid && chk_clear) ? chk_match : '0)
                 | ((ins_valid && ins_defer) ? ins_match : '0);
    end

    for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_slot
        sltab_entry #(.REG_W(REG_W), .LINE_W(LINE_W)) i_entry (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (wr_v[g]),
            .wr_tag       (ins_reg),
            .wr_line      (ins_line),
            .wr_mask      (ins_mask),
            .kill         (kill_v[g]),
            .st_valid     (st_valid),
            .st_line      (st_line),
            .st_mask      (st_mask),
            .valid_o      (valid_v[g]),
            .tag_o        (tag_v[g]),
            .st_conflict_o(st_hit_v[g])
        );
        assign chk_match[g] = valid_v[g] && (tag_v[g] == chk_reg);
        assign ins_match[g] = valid_v[g] && (tag_v[g] == ins_reg);
    end

    sltab_victim #(.ENTRIES(ENTRIES)) i_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (alloc),
        .valid_i   (valid_v),
        .same_reg_i(ins_match),
        .sel_o     (sel_v)
    );

    assign chk_hit = chk_valid && (|chk_match);

    // R8: a register never owns more than one live entry
    a_r8_unique_reg: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> $onehot0(chk_match));

    // R6: a clearing check leaves no live entry for its register
    a_r6_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_clear && !ins_valid) |=> ((valid_v & $past(chk_match)) == '0));

    // R7: a deferred insert leaves no live entry for its register
    a_r7_defer_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_defer) |=> ((valid_v & $past(ins_match)) == '0));

    // R4: overlapping slots are gone after a store that came with no insert
    a_r4_store_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !ins_valid) |=> ((valid_v & $past(st_hit_v)) == '0));
endmodule

// File: tb/test_spec_ld_table.sv
module test_spec_ld_table;
    localparam int unsigned ENTRIES = 4;
    localparam int unsigned REG_W   = 6;
    localparam int unsigned ADDR_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_valid = 1'b0, ins_defer = 1'b0;
    logic [REG_W-1:0]  ins_reg = '0;
    logic [ADDR_W-1:0] ins_addr = '0;
    logic [1:0]        ins_size = '0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [1:0]        st_size = '0;
    logic              chk_valid = 1'b0, chk_clear = 1'b0;
    logic [REG_W-1:0]  chk_reg = '0;
    logic              chk_hit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    spec_ld_table #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) i_spec_ld_table (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_defer(ins_defer), .ins_reg(ins_reg),
        .ins_addr(ins_addr), .ins_size(ins_size),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .chk_valid(chk_valid), .chk_clear(chk_clear), .chk_reg(chk_reg),
        .chk_hit(chk_hit)
    );

    // Monitor: compare the combinational result mid-cycle against the queue
    always @(negedge clk) begin
        if (rst_n && chk_valid) begin
            bit e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL %s: unexpected check, actual=%0b expected=none", "R3", chk_hit);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (chk_hit !== e) begin
                    failures++;
                    $display("FAIL %s: chk_hit actual=%0b expected=%0b", t, chk_hit, e);
                end
            end
        end
        if (rst_n && !chk_valid) begin
            checks++;
            if (chk_hit !== 1'b0) begin
                failures++;
                $display("FAIL R3: idle chk_hit actual=%0b expected=0", chk_hit);
            end
        end
    end

    // Driver: one cycle of stimulus on all ports
    task automatic step(input bit iv, input bit idf, input int ir, input int ia, input int isz,
                        input bit sv, input int sa, input int ssz,
                        input bit cv, input bit cc, input int cr,
                        input bit exp, input string t);
        @(posedge clk);
        #1;
        ins_valid = iv; ins_defer = idf; ins_reg = REG_W'(ir);
        ins_addr = ADDR_W'(ia); ins_size = 2'(isz);
        st_valid = sv; st_addr = ADDR_W'(sa); st_size = 2'(ssz);
        chk_valid = cv; chk_clear = cc; chk_reg = REG_W'(cr);
        if (cv) begin
            exp_q.push_back(exp);
            tag_q.push_back(t);
        end
    endtask

    task automatic ins(input int r, input int a, input int sz);
        step(1, 0, r, a, sz, 0, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic defer_ins(input int r);
        step(1, 1, r, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic st(input int a, input int sz);
        step(0, 0, 0, 0, 0, 1, a, sz, 0, 0, 0, 0, "");
    endtask
    task automatic chk(input int r, input bit exp, input string t);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, r, exp, t);
    endtask
    task automatic chk_clr(input int r, input bit exp, input string t);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, r, exp, t);
    endtask
    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        ins_valid = 0; st_valid = 0; chk_valid = 0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: empty after reset
        chk(5, 0, "R1");
        // R2: insert then hit
        ins(5, 'h100, 3);
        chk(5, 1, "R2");
        chk(6, 0, "R2");
        // R3: same-cycle check sees old state
        step(1, 0, 7, 'h200, 3, 0, 0, 0, 1, 0, 7, 0, "R3");
        chk(7, 1, "R3");
        // R4: overlapping store removes, others stay
        st('h104, 2);
        chk(5, 0, "R4");
        chk(7, 1, "R4");
        // R5: byte-lane overlap rules
        ins(8, 'h300, 2);
        st('h304, 2);
        chk(8, 1, "R5");
        st('h308, 3);
        chk(8, 1, "R5");
        st('h302, 0);
        chk(8, 0, "R5");
        ins(8, 'h306, 2);
        st('h308, 0);
        chk(8, 1, "R5");
        st('h307, 0);
        chk(8, 0, "R5");
        // R6: clearing check
        ins(9, 'h400, 3);
        chk_clr(9, 1, "R6");
        chk(9, 0, "R6");
        chk_clr(9, 0, "R6");
        // R7: deferred insert
        defer_ins(10);
        chk(10, 0, "R7");
        ins(10, 'h480, 3);
        chk(10, 1, "R7");
        defer_ins(10);
        chk(10, 0, "R7");
        // R8: overwrite in place
        ins(11, 'h500, 3);
        ins(11, 'h600, 3);
        chk(11, 1, "R8");
        st('h500, 3);
        chk(11, 1, "R8");
        st('h600, 3);
        chk(11, 0, "R8");
        // R9: insert and store together
        step(1, 0, 12, 'h700, 3, 1, 'h700, 0, 0, 0, 0, 0, "");
        chk(12, 0, "R9");
        step(1, 0, 13, 'h800, 3, 1, 'h900, 3, 0, 0, 0, 0, "");
        chk(13, 1, "R9");
        step(1, 0, 13, 'hA00, 3, 1, 'h800, 3, 0, 0, 0, 0, "");
        chk(13, 1, "R9");
        // R12: insert beats clearing check
        step(1, 0, 13, 'hB00, 3, 0, 0, 0, 1, 1, 13, 1, "R12");
        chk(13, 1, "R12");
        st('hB00, 3);
        chk(13, 0, "R12");
        // R1: reset empties the table
        do_reset();
        chk(7, 0, "R1");
        // R10 / R11: fill, evict, reuse
        ins(20, 'h1000, 3);
        ins(21, 'h1008, 3);
        ins(22, 'h1010, 3);
        ins(23, 'h1018, 3);
        chk(20, 1, "R11");
        ins(24, 'h1020, 3);
        chk(20, 0, "R10");
        chk(24, 1, "R10");
        chk(21, 1, "R10");
        ins(25, 'h1028, 3);
        chk(21, 0, "R10");
        chk(22, 1, "R10");
        chk_clr(23, 1, "R11");
        ins(26, 'h1030, 3);
        chk(22, 1, "R11");
        chk(26, 1, "R11");
        chk(23, 0, "R11");
        ins(27, 'h1038, 3);
        chk(22, 0, "R10");
        chk(24, 1, "R10");
        chk(27, 1, "R10");
        idle();
        idle();
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R3: %0d checks never observed, actual=%0d expected=0", exp_q.size(), exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule